// File: doc/BRIEF.md
# Pipeline Hazard Interlock and Bypass Control

This block is the hazard controller for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it takes the register fields and control bits of the instruction in decode. It carries them forward in its own shadow of the decode/execute, execute/memory and memory/writeback control registers. From that state it computes everything the datapath needs to keep dependent instructions correct without software scheduling.

For the instruction in execute it picks a source for each ALU operand: the register file, the execute/memory result, or the memory/writeback result. When a load is followed at once by a consumer of the loaded register, it holds the PC and the fetch/decode register for one cycle and turns the decode/execute slot into a bubble. A conditional branch in decode holds fetch for a fixed number of cycles, squashes whatever decode presents during that time, and signals a redirect in the last cycle of the hold if the branch is taken.

Only read-after-write cases are checked. Every instruction reads in decode and writes in writeback, so the other orderings cannot occur. A producer three slots ahead needs no bypass, because the register file writes in the first half of the cycle and reads in the second.

Top module: `pipe_hazard_unit`

## Requirements
- R1: When the execute-stage instruction has a source equal to the destination of the instruction one slot ahead (execute/memory) and that instruction has its register-write enable set, the select for that operand is 2'b10.
- R2: When the only such match is with the instruction two slots ahead (memory/writeback), with its write enable set, the select is 2'b01.
- R3: When both the execute/memory and the memory/writeback destinations match a source, the select is 2'b10, because the younger producer wins.
- R4: The select is 2'b00 when no older instruction that has its write enable set matches. This includes a producer three or more slots ahead and a matching producer whose write enable is clear.
- R5: Register 0 never causes a bypass select other than 2'b00 and never causes a stall.
- R6: stall_o and bubble_o are high in any cycle where decode reads a nonzero register that is the destination of the execute-stage instruction, and that instruction has both its memory-read enable and its register-write enable set. The stall lasts exactly one cycle. When the held consumer reaches execute, the loaded value is selected with 2'b01.
- R7: In the cycle after bubble_o is high, ex_reg_wr_o, ex_mem_rd_o and ex_mem_wr_o are 0 and both bypass selects are 2'b00. In any other cycle those three outputs equal the decode enables of the previous cycle.
- R8: A branch accepted in decode sets fetch_hold_o high for FREEZE cycles (3 by default), starting in its own decode cycle. In the FREEZE-1 cycles after acceptance, bubble_o is high and all decode fields, including the branch flag, are ignored.
- R9: redirect_o equals br_taken_i in the last cycle of a branch hold and is 0 in every other cycle.
- R10: A load-use stall takes priority over a branch in decode. The branch is not accepted in the stall cycle (fetch_hold_o low) and is accepted when it is presented again.
- R11: While reset is asserted and right after it is released, all outputs are 0 and the shadow stage registers are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_rs1_i | input | 5 | First source register of the decode instruction |
| id_rs2_i | input | 5 | Second source register of the decode instruction |
| id_rd_i | input | 5 | Destination register of the decode instruction |
| id_reg_wr_i | input | 1 | Decode instruction writes a register |
| id_mem_rd_i | input | 1 | Decode instruction reads memory (load) |
| id_mem_wr_i | input | 1 | Decode instruction writes memory (store) |
| id_branch_i | input | 1 | Decode instruction is a conditional branch |
| br_taken_i | input | 1 | Branch outcome, valid in the last hold cycle |
| fwd_a_o | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwd_b_o | output | 2 | Operand B source, same encoding |
| stall_o | output | 1 | Hold the PC and the fetch/decode register |
| bubble_o | output | 1 | Load a bubble into decode/execute |
| fetch_hold_o | output | 1 | Branch hold: PC does not advance |
| redirect_o | output | 1 | Taken branch resolved: fetch from the target |
| ex_reg_wr_o | output | 1 | Carried register-write enable of the execute-stage slot |
| ex_mem_rd_o | output | 1 | Carried memory-read enable of the execute-stage slot |
| ex_mem_wr_o | output | 1 | Carried memory-write enable of the execute-stage slot |

## Verification
The stall, bubble, fetch-hold and redirect outputs are combinational in the current decode fields and the registered stages, so they are sampled in the same cycle the decode fields are driven. The bypass selects and the carried execute enables describe the slot that entered execute at the last edge, so they are sampled one cycle after the consumer was driven in decode. A stalled consumer is driven again in the following cycle and is checked one cycle after that. The bench drives decode right after the rising edge and samples at the falling edge of the cycle where each result is due. It sweeps producer kind, producer distance, register number and operand position, and it runs branch holds with and without a taken outcome.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/phz_stage_regs.sv
module phz_stage_regs #(
  parameter int RAW = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bubble_i,
  input  logic [RAW-1:0] id_rs1_i,
  input  logic [RAW-1:0] id_rs2_i,
  input  logic [RAW-1:0] id_rd_i,
  input  logic           id_reg_wr_i,
  input  logic           id_mem_rd_i,
  input  logic           id_mem_wr_i,
  output logic [RAW-1:0] ex_rs1_o,
  output logic [RAW-1:0] ex_rs2_o,
  output logic [RAW-1:0] ex_rd_o,
  output logic           ex_reg_wr_o,
  output logic           ex_mem_rd_o,
  output logic           ex_mem_wr_o,
  output logic [RAW-1:0] mem_rd_o,
  output logic           mem_reg_wr_o,
  output logic           mem_mem_rd_o,
  output logic [RAW-1:0] wb_rd_o,
  output logic           wb_reg_wr_o
);

  // decode/execute shadow; a bubble clears fields and enables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_rs1_o    <= '0;
      ex_rs2_o    <= '0;
      ex_rd_o     <= '0;
      ex_reg_wr_o <= 1'b0;
      ex_mem_rd_o <= 1'b0;
      ex_mem_wr_o <= 1'b0;
    end else if (bubble_i) begin
      ex_rs1_o    <= '0;
      ex_rs2_o    <= '0;
      ex_rd_o     <= '0;
      ex_reg_wr_o <= 1'b0;
      ex_mem_rd_o <= 1'b0;
      ex_mem_wr_o <= 1'b0;
    end else begin
      ex_rs1_o    <= id_rs1_i;
      ex_rs2_o    <= id_rs2_i;
      ex_rd_o     <= id_rd_i;
      ex_reg_wr_o <= id_reg_wr_i;
      ex_mem_rd_o <= id_mem_rd_i;
      ex_mem_wr_o <= id_mem_wr_i;
    end
  end

  // later stages never stall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_rd_o     <= '0;
      mem_reg_wr_o <= 1'b0;
      mem_mem_rd_o <= 1'b0;
      wb_rd_o      <= '0;
      wb_reg_wr_o  <= 1'b0;
    end else begin
      mem_rd_o     <= ex_rd_o;
      mem_reg_wr_o <= ex_reg_wr_o;
      mem_mem_rd_o <= ex_mem_rd_o;
      wb_rd_o      <= mem_rd_o;
      wb_reg_wr_o  <= mem_reg_wr_o;
    end
  end

  // R7
  bubble_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_i |=> (!ex_reg_wr_o && !ex_mem_rd_o && !ex_mem_wr_o));

  // R7
  carry_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bubble_i |=> (ex_reg_wr_o == $past(id_reg_wr_i) && ex_mem_rd_o == $past(id_mem_rd_i)));

endmodule

// File: rtl/phz_bypass_sel.sv
module phz_bypass_sel
  import pipe_hazard_pkg::*;
#(
  parameter int RAW = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [RAW-1:0] rs_i,
  input  logic [RAW-1:0] mem_rd_i,
  input  logic           mem_wr_i,
  input  logic [RAW-1:0] wb_rd_i,
  input  logic           wb_wr_i,
  output fwd_sel_e       sel_o
);

  logic mem_hit, wb_hit;

  assign mem_hit = mem_wr_i && (mem_rd_i != '0) && (mem_rd_i == rs_i);
  assign wb_hit  = wb_wr_i  && (wb_rd_i  != '0) && (wb_rd_i  == rs_i);

  // younger producer wins
  always_comb begin
    if (mem_hit)     sel_o = FWD_MEM;
    else if (wb_hit) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end

  // R5
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_i == '0) |-> (sel_o == FWD_RF));

  // R3
  younger_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_i && wb_wr_i && rs_i != '0 && mem_rd_i == rs_i && wb_rd_i == rs_i)
      |-> (sel_o == FWD_MEM));

  // R4
  no_src_no_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_wr_i && !wb_wr_i) |-> (sel_o == FWD_RF));

endmodule

// File: rtl/phz_load_use.sv
module phz_load_use #(
  parameter int RAW = 5
) (
  input  logic [RAW-1:0] ex_rd_i,
  input  logic           ex_reg_wr_i,
  input  logic           ex_mem_rd_i,
  input  logic [RAW-1:0] id_rs1_i,
  input  logic [RAW-1:0] id_rs2_i,
  output logic           hazard_o
);

  logic ld_live;

  assign ld_live  = ex_mem_rd_i && ex_reg_wr_i && (ex_rd_i != '0);
  assign hazard_o = ld_live && ((id_rs1_i == ex_rd_i) || (id_rs2_i == ex_rd_i));

endmodule

// File: rtl/phz_branch_freeze.sv
module phz_branch_freeze #(
  parameter int FREEZE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic branch_i,
  input  logic block_i,
  input  logic taken_i,
  output logic hold_o,
  output logic squash_o,
  output logic redirect_o
);

  localparam int CW = (FREEZE > 1) ? $clog2(FREEZE + 1) : 1;
  localparam logic [CW-1:0] LOADV = CW'(FREEZE - 1);

  logic [CW-1:0] cnt_q;
  logic          accept, last;

  assign accept   = branch_i && !block_i && (cnt_q == '0);
  assign squash_o = (cnt_q != '0);
  assign hold_o   = accept || squash_o;

  generate
    if (FREEZE == 1) begin : g_single
      assign last = accept;
    end else begin : g_multi
      assign last = (cnt_q == CW'(1));
    end
  endgenerate

  assign redirect_o = last && taken_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (accept)      cnt_q <= LOADV;
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  // R9
  redirect_in_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> hold_o);

  // R9
  release_after_resolve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !squash_o);

  // R10
  blocked_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_i && !squash_o) |-> !hold_o);

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import pipe_hazard_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int FREEZE = 3,
  localparam int RAW   = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [RAW-1:0] id_rs1_i,
  input  logic [RAW-1:0] id_rs2_i,
  input  logic [RAW-1:0] id_rd_i,
  input  logic           id_reg_wr_i,
  input  logic           id_mem_rd_i,
  input  logic           id_mem_wr_i,
  input  logic           id_branch_i,
  input  logic           br_taken_i,
  output logic [1:0]     fwd_a_o,
  output logic [1:0]     fwd_b_o,
  output logic           stall_o,
  output logic           bubble_o,
  output logic           fetch_hold_o,
  output logic           redirect_o,
  output logic           ex_reg_wr_o,
  output logic           ex_mem_rd_o,
  output logic           ex_mem_wr_o
);

  logic [RAW-1:0] ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic           ex_reg_wr, ex_mem_rd, mem_reg_wr, mem_mem_rd, wb_reg_wr;
  logic           lu_hazard, squash;
  logic [RAW-1:0] ex_src [2];
  fwd_sel_e       fsel   [2];

  assign bubble_o = lu_hazard || squash;
  assign stall_o  = lu_hazard;

  phz_stage_regs #(.RAW(RAW)) u_stages (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bubble_i     (bubble_o),
    .id_rs1_i     (id_rs1_i),
    .id_rs2_i     (id_rs2_i),
    .id_rd_i      (id_rd_i),
    .id_reg_wr_i  (id_reg_wr_i),
    .id_mem_rd_i  (id_mem_rd_i),
    .id_mem_wr_i  (id_mem_wr_i),
    .ex_rs1_o     (ex_rs1),
    .ex_rs2_o     (ex_rs2),
    .ex_rd_o      (ex_rd),
    .ex_reg_wr_o  (ex_reg_wr),
    .ex_mem_rd_o  (ex_mem_rd),
    .ex_mem_wr_o  (ex_mem_wr_o),
    .mem_rd_o     (mem_rd),
    .mem_reg_wr_o (mem_reg_wr),
    .mem_mem_rd_o (mem_mem_rd),
    .wb_rd_o      (wb_rd),
    .wb_reg_wr_o  (wb_reg_wr)
  );

  assign ex_reg_wr_o = ex_reg_wr;
  assign ex_mem_rd_o = ex_mem_rd;
  assign ex_src[0]   = ex_rs1;
  assign ex_src[1]   = ex_rs2;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    phz_bypass_sel #(.RAW(RAW)) u_sel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rs_i     (ex_src[g]),
      .mem_rd_i (mem_rd),
      .mem_wr_i (mem_reg_wr),
      .wb_rd_i  (wb_rd),
      .wb_wr_i  (wb_reg_wr),
      .sel_o    (fsel[g])
    );
  end

  assign fwd_a_o = fsel[0];
  assign fwd_b_o = fsel[1];

  phz_load_use #(.RAW(RAW)) u_lduse (
    .ex_rd_i     (ex_rd),
    .ex_reg_wr_i (ex_reg_wr),
    .ex_mem_rd_i (ex_mem_rd),
    .id_rs1_i    (id_rs1_i),
    .id_rs2_i    (id_rs2_i),
    .hazard_o    (lu_hazard)
  );

  phz_branch_freeze #(.FREEZE(FREEZE)) u_brfrz (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .branch_i   (id_branch_i),
    .block_i    (lu_hazard),
    .taken_i    (br_taken_i),
    .hold_o     (fetch_hold_o),
    .squash_o   (squash),
    .redirect_o (redirect_o)
  );

  // R6
  single_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);

  // R6
  no_mem_fwd_of_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_mem_rd |-> (fwd_a_o != 2'b10 && fwd_b_o != 2'b10));

  // R10
  stall_excl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !fetch_hold_o);

  // R8
  squash_bubbles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_hold_o && !$past(fetch_hold_o) && FREEZE > 1) |=> bubble_o);

endmodule

// File: tb/pipe_hazard_unit_tb.sv
`timescale 1ns/1ps
module pipe_hazard_unit_tb;
  localparam int RAW = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [RAW-1:0] id_rs1, id_rs2, id_rd;
  logic id_reg_wr, id_mem_rd, id_mem_wr, id_branch, br_taken;
  logic [1:0] fwd_a_o, fwd_b_o;
  logic stall_o, bubble_o, fetch_hold_o, redirect_o;
  logic ex_reg_wr_o, ex_mem_rd_o, ex_mem_wr_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pipe_hazard_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_rd_i(id_rd),
    .id_reg_wr_i(id_reg_wr), .id_mem_rd_i(id_mem_rd), .id_mem_wr_i(id_mem_wr),
    .id_branch_i(id_branch), .br_taken_i(br_taken),
    .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o), .stall_o(stall_o), .bubble_o(bubble_o),
    .fetch_hold_o(fetch_hold_o), .redirect_o(redirect_o),
    .ex_reg_wr_o(ex_reg_wr_o), .ex_mem_rd_o(ex_mem_rd_o), .ex_mem_wr_o(ex_mem_wr_o)
  );

  task automatic chk1(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk2(string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02b expected %02b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic put(logic [RAW-1:0] s1, logic [RAW-1:0] s2, logic [RAW-1:0] d,
                     logic wr, logic mrd, logic mwr, logic br);
    id_rs1 = s1; id_rs2 = s2; id_rd = d;
    id_reg_wr = wr; id_mem_rd = mrd; id_mem_wr = mwr; id_branch = br;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic nop();
    put(5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) begin
      nop();
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    nop();
    br_taken = 1'b0;
    repeat (2) @(negedge clk);
    // R11 during reset
    chk1("R11 stall in reset", stall_o, 1'b0);
    chk1("R11 hold in reset", fetch_hold_o, 1'b0);
    chk2("R11 fwd_a in reset", fwd_a_o, 2'b00);
    tick();
    rst_ni = 1'b1;
    @(negedge clk);
    chk1("R11 ex_reg_wr after reset", ex_reg_wr_o, 1'b0);
    chk1("R11 bubble after reset", bubble_o, 1'b0);
    chk1("R11 redirect after reset", redirect_o, 1'b0);
    chk2("R11 fwd_b after reset", fwd_b_o, 2'b00);
    tick();

    // sweep: producer kind x distance x register x operand position
    for (int kind = 0; kind < 2; kind++)
      for (int d = 1; d <= 3; d++)
        for (int ri = 0; ri < 3; ri++)
          for (int op = 0; op < 3; op++) begin
            int r, deff, ee, ea, eb;
            logic lu;
            string tag;
            r = (ri == 0) ? 0 : (ri == 1) ? 5 : 31;
            flush();
            put(5'd0, 5'd0, 5'(r), 1'b1, 1'(kind), 1'b0, 1'b0);
            @(negedge clk);
            chk1("R6 no stall on producer", stall_o, 1'b0);
            tick();
            for (int i = 1; i < d; i++) begin
              nop();
              tick();
            end
            put((op == 1) ? 5'd3 : 5'(r), (op == 0) ? 5'd3 : 5'(r), 5'd9,
                1'b1, 1'b0, 1'b0, 1'b0);
            lu = (kind == 1) && (d == 1) && (r != 0);
            @(negedge clk);
            chk1(r == 0 ? "R5 stall" : "R6 stall", stall_o, lu);
            chk1("R6 bubble", bubble_o, lu);
            chk1("R8 no hold", fetch_hold_o, 1'b0);
            tick();
            deff = d;
            if (lu) begin
              @(negedge clk);
              chk1("R6 single stall", stall_o, 1'b0);
              chk1("R7 bubble reg_wr", ex_reg_wr_o, 1'b0);
              chk2("R7 bubble fwd_a", fwd_a_o, 2'b00);
              tick();
              deff = 2;
            end
            nop();
            @(negedge clk);
            ee = (r == 0) ? 0 : (deff == 1) ? 2 : (deff == 2) ? 1 : 0;
            ea = (op != 1) ? ee : 0;
            eb = (op != 0) ? ee : 0;
            if (lu)                tag = "R6 load value via wb";
            else if (r == 0)       tag = "R5 zero register";
            else if (deff == 1)    tag = "R1 exmem bypass";
            else if (deff == 2)    tag = "R2 memwb bypass";
            else                   tag = "R4 split-cycle no bypass";
            chk2($sformatf("%s op a k%0d d%0d r%0d", tag, kind, d, r), fwd_a_o, 2'(ea));
            chk2($sformatf("%s op b k%0d d%0d r%0d", tag, kind, d, r), fwd_b_o, 2'(eb));
            chk1("R7 carried reg_wr", ex_reg_wr_o, 1'b1);
            tick();
          end

    // R3 priority: both later stages hold r6
    flush();
    put(5'd0, 5'd0, 5'd6, 1'b1, 1'b0, 1'b0, 1'b0); tick();
    put(5'd0, 5'd0, 5'd6, 1'b1, 1'b0, 1'b0, 1'b0); tick();
    put(5'd2, 5'd6, 5'd9, 1'b1, 1'b0, 1'b0, 1'b0); tick();
    nop();
    @(negedge clk);
    chk2("R3 younger wins", fwd_b_o, 2'b10);
    chk2("R3 other operand", fwd_a_o, 2'b00);
    tick();

    // R4 write enable clear: no bypass; R6 load without reg write: no stall
    flush();
    put(5'd0, 5'd0, 5'd6, 1'b0, 1'b1, 1'b0, 1'b0); tick();
    put(5'd6, 5'd6, 5'd9, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk1("R6 load without write no stall", stall_o, 1'b0);
    chk1("R7 carried mem_rd", ex_mem_rd_o, 1'b1);
    tick();
    nop();
    @(negedge clk);
    chk2("R4 write disabled no bypass", fwd_a_o, 2'b00);
    tick();

    // R8/R9 branch hold, not taken then taken
    for (int tk = 0; tk < 2; tk++) begin
      flush();
      br_taken = 1'b0;
      put(5'd1, 5'd2, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      chk1("R8 hold in branch cycle", fetch_hold_o, 1'b1);
      chk1("R8 no bubble in branch cycle", bubble_o, 1'b0);
      chk1("R9 no early redirect", redirect_o, 1'b0);
      tick();
      put(5'd7, 5'd7, 5'd7, 1'b1, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      chk1("R8 hold cycle 2", fetch_hold_o, 1'b1);
      chk1("R8 squash cycle 2", bubble_o, 1'b1);
      chk1("R9 no redirect cycle 2", redirect_o, 1'b0);
      tick();
      br_taken = 1'(tk);
      @(negedge clk);
      chk1("R8 hold cycle 3", fetch_hold_o, 1'b1);
      chk1("R8 squash cycle 3", bubble_o, 1'b1);
      chk1($sformatf("R9 redirect taken=%0d", tk), redirect_o, 1'(tk));
      chk1("R8 ignored reg_wr", ex_reg_wr_o, 1'b0);
      chk1("R8 ignored mem_rd", ex_mem_rd_o, 1'b0);
      chk1("R8 ignored mem_wr", ex_mem_wr_o, 1'b0);
      tick();
      nop();
      br_taken = 1'b1;
      @(negedge clk);
      chk1("R8 release after hold", fetch_hold_o, 1'b0);
      chk1("R9 no redirect outside hold", redirect_o, 1'b0);
      chk1("R8 squashed slot reg_wr", ex_reg_wr_o, 1'b0);
      tick();
      br_taken = 1'b0;
    end

    // R10 load-use stall beats branch acceptance
    flush();
    put(5'd0, 5'd0, 5'd4, 1'b1, 1'b1, 1'b0, 1'b0); tick();
    put(5'd4, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk1("R10 stall", stall_o, 1'b1);
    chk1("R10 branch not accepted", fetch_hold_o, 1'b0);
    tick();
    @(negedge clk);
    chk1("R10 no second stall", stall_o, 1'b0);
    chk1("R10 branch accepted on retry", fetch_hold_o, 1'b1);
    tick();
    nop(); tick();
    nop(); tick();
    flush();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule